// File: doc/BRIEF.md
# Round-Robin Trigger Distributor

This block takes a stream of level-1 accept pulses and hands each accepted event to one of several identical digitizer modules, working through the modules in a fixed rotation. Each digitizer needs a long conversion after it is triggered. Because consecutive events land on different modules, those conversions overlap, and the dead time per event falls roughly by the number of modules in use. The number of modules sharing the stream works like a prescale factor. It is taken from an input, but only while the block is quiet.

The block keeps one busy flag per module. A flag goes up when its module is sent an event. It comes down when the module reports that its conversion is done, or when a fast-clear to that module has finished. An event can reach a module whose flag is still up, because the global busy flag lags the state by one cycle. In that case the module gets a fast-clear pulse instead of a trigger. A global busy output tells the front end to hold off. An L1A that arrives while that output is high is dropped and counted. Every accepted event leaves a record in a small FIFO. Readout software can later use these records to confirm that all modules stayed in step.

Top module: `trig_rotor`

## Requirements
- R1: The k-th L1A accepted since the module count was last loaded (k counted from 0) goes to module k mod N, where N is the loaded module count.
- R2: An accepted event drives its pulse on the chosen module's line from the cycle after the L1A. The pulse lasts W clocks, where W is the pulse-width input and a value of 0 is treated as 1. A later event on the same module restarts the pulse.
- R3: A module's busy flag is set on the clock edge that starts its pulse. The flag clears on an edge where that module's done input is high, unless a new event for that module arrives on the same edge.
- R4: If the chosen module's busy flag is already set when the event is accepted, the module gets a fast-clear pulse of the same width instead of a trigger. Its busy flag clears on the edge that ends that pulse.
- R5: busy_o is high when the current target module's busy flag was set one cycle earlier, or when the FIFO is full. An L1A that arrives while busy_o is high produces no pulse and no record, and it adds 1 to rej_cnt_o.
- R6: Each accepted event appends one 29-bit record to the FIFO. Bits [28:13] hold the event number, [12:9] the module index, bit [8] is 1 for a fast-clear, and bits [7:0] hold the busy flags of all modules just before the event. The FIFO is show-ahead: fifo_rec_o shows the oldest record while fifo_empty_o is low. fifo_rd_i removes that record.
- R7: The FIFO holds 8 records. When it is full, busy_o is high and no record is lost or overwritten. A read and an accept in the same cycle both take effect.
- R8: num_mods_i is loaded only in a cycle where no module is busy, no pulse is active and no L1A is accepted. A value of 0 loads 1, and values above 8 load 8. Loading a new value restarts the rotation at module 0.
- R9: While rst_n is low at a clock edge, all busy flags, pulses, counters and the FIFO are cleared. The module count returns to 1.
- R10: The event number starts at 0 after reset. It advances by one for every accepted event, whether that event was a trigger or a fast-clear, and it is not reset when the module count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l1a_i | input | 1 | Level-1 accept, one clock per event |
| num_mods_i | input | 5 | Requested number of modules in the rotation |
| pulse_w_i | input | 4 | Output pulse width in clocks |
| done_i | input | 8 | Per-module conversion done |
| fifo_rd_i | input | 1 | Remove the oldest record |
| trig_o | output | 8 | Per-module trigger pulses |
| fclr_o | output | 8 | Per-module fast-clear pulses |
| busy_o | output | 1 | Hold-off toward the front end |
| rej_cnt_o | output | 16 | Number of L1As dropped while busy |
| fifo_empty_o | output | 1 | No record waiting |
| fifo_rec_o | output | 29 | Oldest record |

## Verification
Evenly spaced L1As with prompt done returns show whether the rotation gives each module its fair share, with pulses of the right length. Back-to-back L1As with a single module open the one-cycle window in which an event is accepted onto a busy module. This separates the fast-clear path from plain rejection. Withholding done across a full rotation drives busy_o from the target flag. Withholding reads drives it from a full FIFO instead. Further runs change the module count to out-of-range values and while modules are busy, and a long random run mixes reads, done returns and pulse widths.

// File: rtl/trig_rotor_pkg.sv
// Shared constants and types for the round-robin trigger distributor.
// Assumes at most 16 modules, so a module index fits in the record field.
package trig_rotor_pkg;

    localparam int IDX_W  = 4;   // module index field width
    localparam int TNUM_W = 16;  // event number width
    localparam int PW_W   = 4;   // pulse width input width

    typedef enum logic {
        KIND_TRIG = 1'b0,
        KIND_CLR  = 1'b1
    } pulse_kind_e;

endpackage

// File: rtl/tr_chan.sv
// One output channel: it drives a trigger or fast-clear pulse of a
// programmable width and holds the module's busy flag.
// Assumes fire_i is a one-cycle strobe. A new fire restarts any pulse.
module tr_chan
    import trig_rotor_pkg::*;
#(
    parameter int PW_W_P = PW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  pulse_kind_e       kind_i,
    input  logic [PW_W_P-1:0] width_i,
    input  logic              done_i,
    output logic              trig_o,
    output logic              fclr_o,
    output logic              busy_o,
    output logic              active_o
);

    logic [PW_W_P-1:0] cnt_q;
    pulse_kind_e       kind_q;
    logic              busy_q;
    logic              clr_ending;

    // A fast-clear that ends on this edge releases the module.
    assign clr_ending = (cnt_q == PW_W_P'(1)) && (kind_q == KIND_CLR);

    // Pulse timer, pulse kind and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= KIND_TRIG;
            busy_q <= 1'b0;
        end else if (fire_i) begin
            cnt_q  <= (width_i == '0) ? PW_W_P'(1) : width_i;
            kind_q <= kind_i;
            busy_q <= 1'b1;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - PW_W_P'(1);
            if (done_i || clr_ending) busy_q <= 1'b0;
        end
    end

    // Output decode from the timer state.
    always_comb begin
        active_o = (cnt_q != '0);
        trig_o   = active_o && (kind_q == KIND_TRIG);
        fclr_o   = active_o && (kind_q == KIND_CLR);
        busy_o   = busy_q;
    end

    p_fire_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> busy_o);

    p_fire_starts_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (trig_o || fclr_o));

    p_clear_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr_o && clr_ending && !fire_i) |=> !busy_o);

endmodule

// File: rtl/tr_evq.sv
// Show-ahead synchronous FIFO for per-event records.
// Assumes the caller never pushes while full. The FIFO ignores pops while empty.
module tr_evq #(
    parameter int WIDTH = 29,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem[rd_q];

    // Next pointer with wrap for a depth that need not be a power of two.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= data_i;
    end

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && full_o));

    p_push_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> !empty_o);

endmodule

// File: rtl/trig_rotor.sv
// Round-robin trigger distributor. Accepted L1As are sent to modules
// in rotation. A target that is still busy gets a fast-clear. Dropped
// L1As are counted, and every accepted event is logged to a FIFO.
// Assumes l1a_i is one clock per event and that MODS <= 16.
module trig_rotor
    import trig_rotor_pkg::*;
#(
    parameter int MODS       = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          l1a_i,
    input  logic [IDX_W:0]                num_mods_i,
    input  logic [PW_W-1:0]               pulse_w_i,
    input  logic [MODS-1:0]               done_i,
    input  logic                          fifo_rd_i,
    output logic [MODS-1:0]               trig_o,
    output logic [MODS-1:0]               fclr_o,
    output logic                          busy_o,
    output logic [TNUM_W-1:0]             rej_cnt_o,
    output logic                          fifo_empty_o,
    output logic [TNUM_W+IDX_W+MODS:0]    fifo_rec_o
);

    localparam int REC_W = TNUM_W + IDX_W + 1 + MODS;
    localparam int NM_W  = IDX_W + 1;

    logic [MODS-1:0]   busy_vec, active_vec, fire_vec;
    logic [IDX_W-1:0]  ptr_q;
    logic [NM_W-1:0]   nm_q, nm_req;
    logic [TNUM_W-1:0] tnum_q, rej_q;
    logic              tgt_lag_q;
    logic              fifo_full, accept, tgt_busy, idle, at_last;
    pulse_kind_e       kind;
    logic [REC_W-1:0]  rec;

    // Hold-off and accept decision.
    assign busy_o   = tgt_lag_q || fifo_full;
    assign accept   = l1a_i && !busy_o;
    assign tgt_busy = busy_vec[ptr_q];
    assign kind     = tgt_busy ? KIND_CLR : KIND_TRIG;
    assign idle     = !(|busy_vec) && !(|active_vec);
    assign at_last  = ({1'b0, ptr_q} + NM_W'(1)) == nm_q;
    assign rec      = {tnum_q, ptr_q, tgt_busy, busy_vec};
    assign rej_cnt_o = rej_q;

    // Clamp the requested module count to the range 1..MODS.
    always_comb begin
        if (num_mods_i == '0)              nm_req = NM_W'(1);
        else if (num_mods_i > NM_W'(MODS)) nm_req = NM_W'(MODS);
        else                               nm_req = num_mods_i;
    end

    // Rotation pointer, module count, event number and lagged target busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            nm_q      <= NM_W'(1);
            tnum_q    <= '0;
            tgt_lag_q <= 1'b0;
        end else begin
            tgt_lag_q <= tgt_busy;
            if (accept) begin
                ptr_q  <= at_last ? '0 : ptr_q + IDX_W'(1);
                tnum_q <= tnum_q + TNUM_W'(1);
            end else if (idle && (nm_req != nm_q)) begin
                nm_q  <= nm_req;
                ptr_q <= '0;
            end
        end
    end

    // Count L1As dropped while held off.
    always_ff @(posedge clk) begin
        if (!rst_n)                rej_q <= '0;
        else if (l1a_i && busy_o)  rej_q <= rej_q + TNUM_W'(1);
    end

    // One channel per module, fired when the rotation points at it.
    for (genvar k = 0; k < MODS; k++) begin : g_chan
        assign fire_vec[k] = accept && (ptr_q == IDX_W'(k));

        tr_chan #(.PW_W_P(PW_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire_i   (fire_vec[k]),
            .kind_i   (kind),
            .width_i  (pulse_w_i),
            .done_i   (done_i[k]),
            .trig_o   (trig_o[k]),
            .fclr_o   (fclr_o[k]),
            .busy_o   (busy_vec[k]),
            .active_o (active_vec[k])
        );
    end

    tr_evq #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_evq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (accept),
        .data_i  (rec),
        .pop_i   (fifo_rd_i),
        .data_o  (fifo_rec_o),
        .empty_o (fifo_empty_o),
        .full_o  (fifo_full)
    );

    p_ptr_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr_q} < nm_q);

    p_count_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(nm_q));

    p_reject_counted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a_i && busy_o) |=> (rej_cnt_o == $past(rej_cnt_o) + TNUM_W'(1)));

    p_reject_no_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (fire_vec == '0));

    p_one_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec));

    p_event_numbered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tnum_q == $past(tnum_q) + TNUM_W'(1)));

endmodule

// File: tb/trig_rotor_bench.sv
module trig_rotor_bench;

    localparam int PERIOD = 10;
    localparam int M      = 8;
    localparam int DEPTH  = 8;
    localparam int RW     = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l1a_i = 1'b0;
    logic [4:0]    num_mods_i = 5'd3;
    logic [3:0]    pulse_w_i = 4'd2;
    logic [M-1:0]  done_i = '0;
    logic          fifo_rd_i = 1'b0;
    logic [M-1:0]  trig_o, fclr_o;
    logic          busy_o, fifo_empty_o;
    logic [15:0]   rej_cnt_o;
    logic [RW-1:0] fifo_rec_o;

    always #(PERIOD/2) clk = ~clk;

    trig_rotor u_trig_rotor (
        .clk(clk), .rst_n(rst_n), .l1a_i(l1a_i), .num_mods_i(num_mods_i),
        .pulse_w_i(pulse_w_i), .done_i(done_i), .fifo_rd_i(fifo_rd_i),
        .trig_o(trig_o), .fclr_o(fclr_o), .busy_o(busy_o),
        .rej_cnt_o(rej_cnt_o), .fifo_empty_o(fifo_empty_o), .fifo_rec_o(fifo_rec_o)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state.
    int            m_cnt  [M];
    bit            m_clr  [M];
    bit            m_busy [M];
    int            m_ptr, m_nm, m_tnum, m_rej;
    bit            m_lag;
    logic [RW-1:0] m_q [$];

    // Pulse statistics seen at the ports.
    int            rise_t [M];
    int            rise_c [M];
    int            high_t [M];
    logic [M-1:0]  prev_t = '0, prev_c = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [M-1:0] m_vec(input bit sel_clr, input bit want_busy);
        logic [M-1:0] v = '0;
        for (int k = 0; k < M; k++) begin
            if (want_busy) v[k] = m_busy[k];
            else           v[k] = (m_cnt[k] != 0) && (m_clr[k] == sel_clr);
        end
        return v;
    endfunction

    task automatic model_step();
        bit full, bo, acc, idle, new_lag, clr_kind;
        int nmc, fire_k, w;
        logic [M-1:0] bv;
        if (!rst_n) begin
            for (int k = 0; k < M; k++) begin m_cnt[k] = 0; m_clr[k] = 0; m_busy[k] = 0; end
            m_ptr = 0; m_nm = 1; m_tnum = 0; m_rej = 0; m_lag = 0; m_q.delete();
            return;
        end
        full = (m_q.size() == DEPTH);
        bo   = m_lag || full;
        acc  = l1a_i && !bo;
        new_lag = m_busy[m_ptr];
        bv   = m_vec(0, 1);
        idle = 1;
        for (int k = 0; k < M; k++) if (m_busy[k] || m_cnt[k] != 0) idle = 0;
        if (l1a_i && bo) m_rej = (m_rej + 1) % 65536;
        if (fifo_rd_i && m_q.size() > 0) void'(m_q.pop_front());
        fire_k = -1;
        clr_kind = m_busy[m_ptr];
        if (acc) begin
            m_q.push_back({m_tnum[15:0], m_ptr[3:0], clr_kind, bv});
            fire_k = m_ptr;
        end
        w = (pulse_w_i == 0) ? 1 : int'(pulse_w_i);
        for (int k = 0; k < M; k++) begin
            if (k == fire_k) begin
                m_cnt[k] = w; m_clr[k] = clr_kind; m_busy[k] = 1;
            end else begin
                bit ending = (m_cnt[k] == 1) && m_clr[k];
                if (m_cnt[k] > 0) m_cnt[k]--;
                if (done_i[k] || ending) m_busy[k] = 0;
            end
        end
        nmc = (num_mods_i == 0) ? 1 : ((num_mods_i > M) ? M : int'(num_mods_i));
        if (acc) begin
            m_ptr  = (m_ptr == m_nm - 1) ? 0 : m_ptr + 1;
            m_tnum = (m_tnum + 1) % 65536;
        end else if (idle && nmc != m_nm) begin
            m_nm = nmc; m_ptr = 0;
        end
        m_lag = new_lag;
    endtask

    task automatic compare();
        logic [M-1:0] et = m_vec(0, 0);
        logic [M-1:0] ec = m_vec(1, 0);
        bit ebusy = m_lag || (m_q.size() == DEPTH);
        chk(trig_o == et, "R1 trig_o", trig_o, et);
        chk(fclr_o == ec, "R4 fclr_o", fclr_o, ec);
        chk(busy_o == ebusy, "R5 busy_o", busy_o, ebusy);
        chk(rej_cnt_o == m_rej[15:0], "R5 rej_cnt_o", rej_cnt_o, m_rej);
        chk(fifo_empty_o == (m_q.size() == 0), "R7 fifo_empty_o", fifo_empty_o, m_q.size() == 0);
        if (m_q.size() > 0)
            chk(fifo_rec_o == m_q[0], "R6 fifo_rec_o", fifo_rec_o, m_q[0]);
        for (int k = 0; k < M; k++) begin
            if (trig_o[k] && !prev_t[k]) rise_t[k]++;
            if (fclr_o[k] && !prev_c[k]) rise_c[k]++;
            if (trig_o[k]) high_t[k]++;
        end
        prev_t = trig_o;
        prev_c = fclr_o;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic cyc(input bit l1a, input logic [M-1:0] done, input bit rd);
        l1a_i = l1a; done_i = done; fifo_rd_i = rd;
        tick();
        l1a_i = 0; done_i = '0; fifo_rd_i = 0;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) if (!fifo_empty_o) cyc(0, '0, 1);
    endtask

    task automatic clear_stats();
        for (int k = 0; k < M; k++) begin rise_t[k] = 0; rise_c[k] = 0; high_t[k] = 0; end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired, no requirement finished");
        summary();
        $finish;
    end

    initial begin
        clear_stats();
        // R9: reset state.
        @(negedge clk);
        tick();
        tick();
        chk(trig_o == '0 && fclr_o == '0, "R9 pulses in reset", {trig_o, fclr_o}, 0);
        chk(busy_o == 0 && rej_cnt_o == 0, "R9 busy/rej in reset", {busy_o, rej_cnt_o}, 0);
        chk(fifo_empty_o == 1, "R9 fifo empty in reset", fifo_empty_o, 1);
        rst_n = 1;
        idle_n(3);

        // R1 R2 R3: N=3, width 2, prompt done returns.
        clear_stats();
        for (int i = 0; i < 6; i++) begin
            cyc(1, '0, 0);
            idle_n(2);
            cyc(0, M'(1) << (i % 3), 0);
            idle_n(1);
        end
        for (int k = 0; k < 3; k++)
            chk(rise_t[k] == 2, "R1 triggers per module", rise_t[k], 2);
        chk(high_t[0] == 4, "R2 trigger high cycles", high_t[0], 4);
        chk(busy_o == 0, "R3 done released all", busy_o, 0);
        drain();

        // R4 R8 R10: one module, back-to-back L1As.
        num_mods_i = 5'd1;
        idle_n(3);
        clear_stats();
        cyc(1, '0, 0);
        cyc(1, '0, 0);
        cyc(1, '0, 0);
        chk(rej_cnt_o == 1, "R5 third L1A dropped", rej_cnt_o, 1);
        idle_n(4);
        chk(rise_c[0] == 1, "R4 one fast-clear", rise_c[0], 1);
        chk(busy_o == 0, "R4 fast-clear released module", busy_o, 0);
        chk(fifo_rec_o[8] == 0 && fifo_rec_o[28:13] == 16'd6, "R10 first record number", fifo_rec_o, 6);
        cyc(0, '0, 1);
        chk(fifo_rec_o[8] == 1 && fifo_rec_o[28:13] == 16'd7, "R4 fast-clear record", fifo_rec_o, 7);
        drain();

        // R5: N=4, no done returns, width 1.
        num_mods_i = 5'd4;
        pulse_w_i  = 4'd1;
        idle_n(3);
        for (int i = 0; i < 5; i++) begin cyc(1, '0, 0); idle_n(1); end
        chk(busy_o == 1, "R5 busy with all modules held", busy_o, 1);
        chk(rej_cnt_o == 2, "R5 fifth L1A dropped", rej_cnt_o, 2);
        // R8: count change ignored while busy.
        num_mods_i = 5'd2;
        cyc(0, 8'h0F, 0);
        idle_n(1);
        cyc(1, '0, 0);
        idle_n(2);
        cyc(0, 8'hFF, 0);
        idle_n(3);
        drain();

        // R7: fill the FIFO with N=2.
        clear_stats();
        for (int i = 0; i < 9; i++) begin
            cyc(1, '0, 0);
            cyc(0, 8'hFF, 0);
        end
        chk(busy_o == 1, "R7 busy on full FIFO", busy_o, 1);
        chk(rise_t[0] + rise_t[1] == 8, "R7 eight events accepted", rise_t[0] + rise_t[1], 8);
        cyc(1, '0, 1);
        idle_n(1);
        drain();

        // R8: clamp of 0 and of 12.
        num_mods_i = 5'd0;
        idle_n(3);
        clear_stats();
        cyc(1, '0, 0); cyc(0, 8'hFF, 0); idle_n(1);
        cyc(1, '0, 0); cyc(0, 8'hFF, 0); idle_n(1);
        chk(rise_t[0] == 2, "R8 zero loads one module", rise_t[0], 2);
        drain();
        num_mods_i = 5'd12;
        idle_n(3);
        clear_stats();
        for (int i = 0; i < 9; i++) begin
            cyc(1, '0, 1); cyc(0, 8'hFF, 1); idle_n(1);
        end
        chk(rise_t[7] == 1 && rise_t[0] == 2, "R8 twelve clamps to eight", {rise_t[7], rise_t[0]}, 2);
        drain();

        // Mixed random traffic with N=5.
        num_mods_i = 5'd5;
        idle_n(3);
        for (int i = 0; i < 600; i++) begin
            if (i % 97 == 0) pulse_w_i = 4'($urandom_range(0, 15));
            cyc(($urandom_range(0, 2) == 0), M'($urandom_range(0, 255)) & M'($urandom_range(0, 255)),
                ($urandom_range(0, 3) != 0));
        end
        drain();

        summary();
        $finish;
    end

endmodule